// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a register-mapped timer peripheral. It has three down-counting channels and one free-running up-counting timestamp. The first two channels are narrow (16 bits by default) and the third is wide (32 bits by default). Each channel is started through its control register and counts on one of two single-cycle tick-enable inputs. When it counts past zero it raises a pending interrupt. In periodic mode it restarts from its load value, so with a load value of L the underflow period is L+1 ticks. In the other mode it wraps to all ones and keeps counting.

The timestamp is 40 bits wide and always counts on the fast tick while it is enabled. Software reads it as a low word and a high word, and it never interrupts. The whole block runs on one system clock with a synchronous active-high reset. Register reads are combinational from the address. Writes take effect on the next clock edge.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero and all interrupt outputs are low.
- R2: The channel register groups start at offsets 0x00, 0x20 and 0x80. Within a group, word 0 is the reload value, word 1 is the live count (read-only), word 2 is control and word 3 is interrupt clear. The timestamp low word is at 0x60 and the high word is at 0x64. Any other offset reads zero, including any offset whose low two bits are not zero.
- R3: A write to the reload word stores the value, truncated to the channel width, and copies it into the count at the same edge. A write to the count word has no effect.
- R4: Control bit 7 enables the channel, bit 6 selects periodic mode, and bit 3 selects tick_slow (1) or tick_fast (0). The count changes only on cycles where the channel is enabled and its selected tick is high. The control word reads back these three bits and zeros elsewhere.
- R5: In periodic mode a tick that finds the count at zero reloads it from the reload word, giving an underflow every L+1 ticks.
- R6: In non-periodic mode a tick at zero wraps the count to all ones of the channel width.
- R7: An underflow makes that channel's interrupt output high from the next cycle. Any write to the clear word drops it. If a clear and an underflow fall in the same cycle, the interrupt stays high.
- R8: While a channel is disabled, its interrupt output is low from the following cycle.
- R9: While enabled, the timestamp adds one on each tick_fast cycle, wrapping at 40 bits. Offset 0x60 returns bits 31:0. Offset 0x64 returns bits 39:32 in bits 7:0 and the enable state in bit 8.
- R10: Writing 0x64 with bit 8 set enables the timestamp. Writing it with bit 8 clear stops the timestamp and zeroes it. Writes to 0x60 have no effect.
- R11: A reload write in the same cycle as a counting tick wins: the count becomes the written value and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_slow | input | 1 | Slow single-cycle tick enable |
| tick_fast | input | 1 | Fast single-cycle tick enable, also drives the timestamp |
| irq | output | 3 | Per-channel pending interrupt, bit 0 is the channel at 0x00 |

## Verification
The bench builds the bank with a narrow channel width of 8 and a wide channel width of 12, and keeps the 40-bit timestamp. With these widths the non-periodic wrap to all ones and the long count back down from it fit within a short run. Reload truncation to the channel width can then be seen at the bus. A reference model runs in lockstep with the design and compares the read data and all interrupt lines on every cycle. Most of its bits and decisions are the same at the default widths. Carry into the timestamp high word would need more than four billion ticks, so the bench checks that word only for its zero value and its enable bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH       = 3;
  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_PER_BIT = 6;
  localparam int CTRL_SLW_BIT = 3;
  localparam int STAMP_EN_BIT = 8;
  localparam logic [7:0] STAMP_LO_OFF = 8'h60;
  localparam logic [7:0] STAMP_HI_OFF = 8'h64;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_VALUE = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } chan_reg_e;

  typedef struct packed {
    logic en;
    logic periodic;
    logic slow;
  } chan_ctrl_t;

  function automatic logic [7:0] chan_base(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic int chan_width(input int idx, input int narrow_w, input int wide_w);
    return (idx == NUM_CH - 1) ? wide_w : narrow_w;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic             wr_clear,
  input  logic [W-1:0]     load_data,
  input  chan_ctrl_t       ctrl_data,
  input  logic             tick_slow,
  input  logic             tick_fast,
  output logic [W-1:0]     load_q,
  output logic [W-1:0]     cnt_q,
  output chan_ctrl_t       ctrl_q,
  output logic             irq
);
  logic step;
  logic underflow;

  function automatic logic [W-1:0] count_next(input logic [W-1:0] c,
                                              input logic [W-1:0] ld,
                                              input logic per);
    if (c == '0) return per ? ld : {W{1'b1}};
    return c - 1'b1;
  endfunction

  assign step      = ctrl_q.en && (ctrl_q.slow ? tick_slow : tick_fast);
  assign underflow = step && (cnt_q == '0) && !wr_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_data;
      if (wr_load) begin
        load_q <= load_data;
        cnt_q  <= load_data;
      end else if (step) begin
        cnt_q <= count_next(cnt_q, load_q, ctrl_q.periodic);
      end
      if (underflow)                      irq <= 1'b1;
      else if (!ctrl_q.en || wr_clear)    irq <= 1'b0;
    end
  end

  a_r3_load_copies: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> cnt_q == $past(load_data));
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr_load && !step) |=> $stable(cnt_q));
  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (rst)
    (underflow && ctrl_q.periodic) |=> cnt_q == $past(load_q));
  a_r6_wrap_all_ones: assert property (@(posedge clk) disable iff (rst)
    (underflow && !ctrl_q.periodic) |=> (&cnt_q));
  a_r7_underflow_raises: assert property (@(posedge clk) disable iff (rst)
    underflow |=> irq);
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_clear && !underflow) |=> !irq);
  a_r8_disable_drops: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.en |=> !irq);
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp
  import tmr_pkg::*;
#(
  parameter int W  = 40,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hi,
  input  logic          en_data,
  input  logic          tick,
  output logic [W-1:0]  cnt_q,
  output logic          en_q
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] c);
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_hi) en_q <= en_data;
      if (wr_hi && !en_data)  cnt_q <= '0;
      else if (en_q && tick)  cnt_q <= bump(cnt_q);
    end
  end

  a_r10_stopped_is_zero: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> cnt_q == '0);
  a_r9_counts_up: assert property (@(posedge clk) disable iff (rst)
    (en_q && tick && !wr_hi) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r9_holds_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_hi) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int STAMP_W  = 40,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               tick_slow,
  input  logic               tick_fast,
  output logic [NUM_CH-1:0]  irq
);
  localparam int HI_W = STAMP_W - DATA_W;

  logic [DATA_W-1:0] ch_rd [NUM_CH];
  chan_reg_e         reg_sel;
  chan_ctrl_t        ctrl_wr;

  assign reg_sel = chan_reg_e'(bus_addr[3:2]);
  assign ctrl_wr = '{en:       bus_wdata[CTRL_EN_BIT],
                     periodic: bus_wdata[CTRL_PER_BIT],
                     slow:     bus_wdata[CTRL_SLW_BIT]};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int CW = chan_width(ch, NARROW_W, WIDE_W);
    logic          hit;
    logic [CW-1:0] load_q, cnt_q;
    chan_ctrl_t    ctrl_q;

    assign hit = (bus_addr[ADDR_W-1:4] == chan_base(ch)[ADDR_W-1:4]) &&
                 (bus_addr[1:0] == 2'b00);

    tmr_chan #(.W(CW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_load   (bus_wr && hit && reg_sel == REG_LOAD),
      .wr_ctrl   (bus_wr && hit && reg_sel == REG_CTRL),
      .wr_clear  (bus_wr && hit && reg_sel == REG_CLEAR),
      .load_data (bus_wdata[CW-1:0]),
      .ctrl_data (ctrl_wr),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .load_q    (load_q),
      .cnt_q     (cnt_q),
      .ctrl_q    (ctrl_q),
      .irq       (irq[ch])
    );

    always_comb begin
      ch_rd[ch] = '0;
      if (hit) begin
        case (reg_sel)
          REG_LOAD:  ch_rd[ch] = DATA_W'(load_q);
          REG_VALUE: ch_rd[ch] = DATA_W'(cnt_q);
          REG_CTRL: begin
            ch_rd[ch][CTRL_EN_BIT]  = ctrl_q.en;
            ch_rd[ch][CTRL_PER_BIT] = ctrl_q.periodic;
            ch_rd[ch][CTRL_SLW_BIT] = ctrl_q.slow;
          end
          default:   ch_rd[ch] = '0;
        endcase
      end
    end
  end

  logic [STAMP_W-1:0] st_cnt;
  logic               st_en;
  logic               st_wr_hi;

  assign st_wr_hi = bus_wr && (bus_addr == ADDR_W'(STAMP_HI_OFF));

  tmr_stamp #(.W(STAMP_W), .DW(DATA_W)) u_stamp (
    .clk     (clk),
    .rst     (rst),
    .wr_hi   (st_wr_hi),
    .en_data (bus_wdata[STAMP_EN_BIT]),
    .tick    (tick_fast),
    .cnt_q   (st_cnt),
    .en_q    (st_en)
  );

  always_comb begin
    bus_rdata = '0;
    for (int ch = 0; ch < NUM_CH; ch++) bus_rdata = bus_rdata | ch_rd[ch];
    if (bus_addr == ADDR_W'(STAMP_LO_OFF)) bus_rdata = st_cnt[DATA_W-1:0];
    if (bus_addr == ADDR_W'(STAMP_HI_OFF)) begin
      bus_rdata = '0;
      bus_rdata[HI_W-1:0]   = st_cnt[STAMP_W-1:DATA_W];
      bus_rdata[STAMP_EN_BIT] = st_en;
    end
  end

  a_r2_one_channel_decoded: assert property (@(posedge clk) disable iff (rst)
    $onehot0({g_ch[0].hit, g_ch[1].hit, g_ch[2].hit}));
endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
  localparam int NW = 8;
  localparam int WW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tmr_bank #(.NARROW_W(NW), .WIDE_W(WW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq));

  // reference model state
  logic [31:0] m_load [3];
  logic [31:0] m_cnt  [3];
  bit          m_en [3], m_per [3], m_slow [3], m_pend [3];
  longint      m_st;
  bit          m_sen;

  function automatic logic [31:0] wmask(int i);
    return (i == 2) ? ((32'd1 << WW) - 1) : ((32'd1 << NW) - 1);
  endfunction

  function automatic int base_of(int i);
    return (i == 0) ? 'h00 : (i == 1) ? 'h20 : 'h80;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a == 8'h60) return m_st[31:0];
    if (a == 8'h64) return {23'd0, m_sen, m_st[39:32]};
    if (a[1:0] != 0) return 0;
    for (int i = 0; i < 3; i++) begin
      if ((a >> 4) == (base_of(i) >> 4)) begin
        case (a[3:2])
          0: return m_load[i];
          1: return m_cnt[i];
          2: return (32'(m_en[i]) << 7) | (32'(m_per[i]) << 6) | (32'(m_slow[i]) << 3);
          default: return 0;
        endcase
      end
    end
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_load[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_per[i] = 0; m_slow[i] = 0; m_pend[i] = 0;
    end
    m_st = 0; m_sen = 0;
  endtask

  task automatic model_update(bit wr, logic [7:0] a, logic [31:0] wd, bit ts, bit tf);
    for (int i = 0; i < 3; i++) begin
      bit hit   = (a[1:0] == 0) && ((a >> 4) == (base_of(i) >> 4));
      bit wl    = wr && hit && a[3:2] == 0;
      bit wc    = wr && hit && a[3:2] == 2;
      bit wclr  = wr && hit && a[3:2] == 3;
      bit tk    = m_en[i] && (m_slow[i] ? ts : tf);
      bit uf    = tk && m_cnt[i] == 0 && !wl;
      bit old_en = m_en[i];
      if (wl) begin
        m_load[i] = wd & wmask(i);
        m_cnt[i]  = wd & wmask(i);
      end else if (tk) begin
        if (m_cnt[i] == 0) m_cnt[i] = m_per[i] ? m_load[i] : wmask(i);
        else               m_cnt[i] = m_cnt[i] - 1;
      end
      if (uf) m_pend[i] = 1;
      else if (!old_en || wclr) m_pend[i] = 0;
      if (wc) begin
        m_en[i] = wd[7]; m_per[i] = wd[6]; m_slow[i] = wd[3];
      end
    end
    if (wr && a == 8'h64 && !wd[8]) m_st = 0;
    else if (m_sen && tf) m_st = (m_st + 1) & 64'hFF_FFFF_FFFF;
    if (wr && a == 8'h64) m_sen = wd[8];
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit wr, logic [7:0] a, logic [31:0] wd, bit ts, bit tf);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; tick_slow = ts; tick_fast = tf;
    #1;
    check(tag, "rdata", bus_rdata, model_read(a));
    check(tag, "irq", {29'd0, irq}, {29'd0, m_pend[2], m_pend[1], m_pend[0]});
    model_update(wr, a, wd, ts, tf);
  endtask

  task automatic rd(string tag, logic [7:0] a);
    step(tag, 1'b0, a, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
    step(tag, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  initial begin
    #(100_000 * 4);
    checks++; errors++;
    $display("FAIL watchdog all actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of all registers
    foreach (u_chk_addr[k]) rd("R1", u_chk_addr[k]);

    // R2: unmapped and misaligned offsets read zero
    rd("R2", 8'h10); rd("R2", 8'h41); rd("R2", 8'h06); rd("R2", 8'hF0);

    // R3: load truncates and copies, value word is read-only
    wr("R3", 8'h00, 32'h0000_01A5);
    rd("R3", 8'h04); rd("R3", 8'h00);
    wr("R3", 8'h04, 32'h0000_0033);
    rd("R3", 8'h04);

    // R4: enable + slow select; fast ticks must not count
    wr("R4", 8'h08, 32'h0000_0088);
    rd("R4", 8'h08);
    for (int k = 0; k < 4; k++) step("R4", 0, 8'h04, 0, 0, 1);
    for (int k = 0; k < 4; k++) step("R4", 0, 8'h04, 0, 1, 0);
    wr("R4", 8'h08, 32'h0000_0008);
    for (int k = 0; k < 3; k++) step("R4", 0, 8'h04, 0, 1, 1);

    // R5: periodic on channel at 0x20, load 3, fast tick
    wr("R5", 8'h20, 32'd3);
    wr("R5", 8'h28, 32'h0000_00C0);
    for (int k = 0; k < 12; k++) step("R5", 0, 8'h24, 0, 0, 1);
    wr("R7", 8'h2C, 32'hDEAD_BEEF);
    rd("R7", 8'h24);
    // R7: clear coinciding with an underflow keeps the interrupt
    step("R7", 0, 8'h24, 0, 0, 1);
    step("R7", 0, 8'h24, 0, 0, 1);
    step("R7", 0, 8'h24, 0, 0, 1);
    step("R7", 1, 8'h2C, 0, 0, 1);
    rd("R7", 8'h24);
    // R8: disabling drops the interrupt
    wr("R8", 8'h28, 32'h0000_0040);
    rd("R8", 8'h24); rd("R8", 8'h28);

    // R6: non-periodic wrap on wide channel
    wr("R6", 8'h80, 32'h0000_F002);
    wr("R6", 8'h88, 32'h0000_0088);
    for (int k = 0; k < 5; k++) step("R6", 0, 8'h84, 0, 1, 0);
    wr("R6", 8'h8C, 32'd0);
    rd("R6", 8'h84);

    // R11: load write in the same cycle as a tick at zero
    wr("R11", 8'h80, 32'd1);
    step("R11", 0, 8'h84, 0, 1, 0);
    step("R11", 1, 8'h80, 32'd7, 1, 0);
    rd("R11", 8'h84);
    wr("R11", 8'h88, 32'd0);

    // R9: timestamp counting and read layout
    rd("R9", 8'h64);
    wr("R9", 8'h64, 32'h0000_0100);
    for (int k = 0; k < 6; k++) step("R9", 0, 8'h60, 0, 0, (k % 2) == 0);
    rd("R9", 8'h64);

    // R10: low write ignored, stop clears
    wr("R10", 8'h60, 32'h1234_5678);
    rd("R10", 8'h60);
    wr("R10", 8'h64, 32'h0000_00FF);
    rd("R10", 8'h60); rd("R10", 8'h64);
    step("R10", 0, 8'h60, 0, 0, 1);

    // mixed traffic on all channels, compared every cycle (R4, R5, R7)
    wr("R4", 8'h64, 32'h100);
    wr("R5", 8'h00, 32'd5);  wr("R5", 8'h08, 32'hC8);
    wr("R5", 8'h20, 32'd2);  wr("R5", 8'h28, 32'hC0);
    wr("R6", 8'h80, 32'd9);  wr("R6", 8'h88, 32'h80);
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a = u_chk_addr[$urandom_range(0, 13)];
      bit w = ($urandom_range(0, 19) == 0) && (a[3:2] == 3);
      step("R7", w, a, $urandom, $urandom_range(0, 1), $urandom_range(0, 1));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [7:0] u_chk_addr [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h24, 8'h28,
                                  8'h2C, 8'h80, 8'h84, 8'h88, 8'h8C, 8'h60, 8'h64};
endmodule